// File: doc/BRIEF.md
# Data-Ready Triggered Converter Serial Reader

This block is a serial-bus master for a group of delta-sigma converters that run as slaves and sample in step. It watches one shared active-low ready line. Each time that line falls, the block runs one 32-bit frame. The frame sends an 8-bit read command and then 24 zero bits. At the same time it shifts in the 24-bit conversion result, which it then presents on a parallel output with a one-cycle strobe.

A host may also queue one register-write frame at a time through a small request port. The frame carries the host's 8-bit command and 24-bit data field. When a read and a write are both waiting, the read goes first and the write follows straight after it.

Every frame opens with an active-low sync pulse. The serial clock idles low, and chip select returns high between frames.

Top module: `adc_ready_reader`

## Requirements
- R1: After reset, csN and fsN are 1, sclk is 0, sampleValid is 0 and wrPending is 0.
- R2: The ready input passes through a two-flop synchronizer. A read frame starts only after a falling edge of the synchronized ready signal, and only while it is still low. A ready line that stays low yields exactly one read frame.
- R3: Every frame begins with fsN low for one full SCLK period, 2*HALF clocks, with csN low and sclk low. csN then stays low through 32 rising SCLK edges.
- R4: Bits leave on mosi most significant bit first. A read frame carries {READ_CMD, 24'h000000}, with READ_CMD defaulting to 8'h01. A write frame carries {wrCmd, wrData} as captured at the accepted request.
- R5: mosi changes only at falling SCLK edges, so it is stable during every SCLK high phase. miso is sampled at rising SCLK edges.
- R6: At the end of a read frame, sample holds the last 24 bits received, first bit most significant, as a two's-complement value. sampleValid is high for exactly one cycle. A write frame produces no sampleValid.
- R7: A wrReq with wrPending at 0 is accepted and sets wrPending. wrPending clears as the write frame ends. A wrReq while wrPending is 1 is ignored and its data is never sent.
- R8: If a read and a write are both pending when the block is idle, the read frame is sent first and the write frame is sent right after it.
- R9: Between frames csN stays high for more than 2*HALF clocks, and sclk is low whenever csN is high.
- R10: While the ready line is high, no read frame starts, but queued write frames are still sent.
- R11: The SCLK period is 2*HALF system clocks, where HALF = SYS_CLK_HZ / (2*SCLK_HZ).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| drdyN | input | 1 | Shared active-low conversion-ready line (asynchronous) |
| miso | input | 1 | Serial data from the converters |
| wrReq | input | 1 | One-cycle request to queue a register-write frame |
| wrCmd | input | 8 | Command byte of the write frame |
| wrData | input | 24 | Data field of the write frame |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the converters |
| csN | output | 1 | Active-low chip select |
| fsN | output | 1 | Active-low frame sync pulse |
| sample | output | 24 | Last conversion result, two's complement |
| sampleValid | output | 1 | One-cycle strobe for a new sample |
| wrPending | output | 1 | A write frame is queued or in flight |

## Verification
The embedded properties check the edge discipline on every cycle: the sync pulse lies inside chip select with the clock low, the clock is idle whenever chip select is high, the chip-select gap meets its minimum length, mosi holds still through each high phase, the valid strobe lasts one cycle, and read frames start only on a ready condition. Other behaviour needs whole scenarios driven by the bench. Those scenarios cover the recovered sample values across a bit-pattern sweep, the exact command words on the wire, single-read-per-edge behaviour under a held-low ready line, ignored write requests, and read-before-write ordering.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  localparam int CMD_W   = 8;
  localparam int DATA_W  = 24;
  localparam int FRAME_W = CMD_W + DATA_W;

  typedef enum logic [1:0] {ST_IDLE, ST_SYNC, ST_SHIFT, ST_GAP} frameState_t;

  typedef struct packed {
    logic loadRead;
    logic loadWrite;
    logic holdWrite;
    logic rise;
    logic fall;
    logic publish;
  } dpStrobe_t;
endpackage

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int HALF = 25
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      drdyN,
  input  logic      wrReq,
  output logic      csN,
  output logic      fsN,
  output logic      wrPending,
  output dpStrobe_t stb
);
  localparam int CNT_W     = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int LAST_HALF = 2 * FRAME_W - 1;
  localparam int IDX_W     = $clog2(2 * FRAME_W);

  logic drdyMeta, drdySync, drdyPrev, readPend, isRead;
  frameState_t state;
  logic [CNT_W-1:0] halfCnt;
  logic [IDX_W-1:0] halfIdx;

  logic halfDone, readyFell, startRead, startWrite, shiftEnd;
  assign halfDone   = (halfCnt == CNT_W'(HALF - 1));
  assign readyFell  = drdyPrev & ~drdySync;
  assign startRead  = (state == ST_IDLE) && readPend && !drdySync;
  assign startWrite = (state == ST_IDLE) && !startRead && wrPending;
  assign shiftEnd   = (state == ST_SHIFT) && halfDone && (halfIdx == IDX_W'(LAST_HALF));

  always_comb begin
    stb.loadRead  = startRead;
    stb.loadWrite = startWrite;
    stb.holdWrite = wrReq && !wrPending;
    stb.rise      = (state == ST_SHIFT) && halfDone && !halfIdx[0];
    stb.fall      = (state == ST_SHIFT) && halfDone && halfIdx[0];
    stb.publish   = shiftEnd && isRead;
  end

  assign csN = !((state == ST_SYNC) || (state == ST_SHIFT));
  assign fsN = !(state == ST_SYNC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      drdyMeta  <= 1'b1;
      drdySync  <= 1'b1;
      drdyPrev  <= 1'b1;
      readPend  <= 1'b0;
      wrPending <= 1'b0;
      isRead    <= 1'b0;
      state     <= ST_IDLE;
      halfCnt   <= '0;
      halfIdx   <= '0;
    end else begin
      drdyMeta <= drdyN;
      drdySync <= drdyMeta;
      drdyPrev <= drdySync;

      if (startRead || drdySync) readPend <= 1'b0;
      else if (readyFell)        readPend <= 1'b1;

      if (shiftEnd && !isRead) wrPending <= 1'b0;
      else if (wrReq)          wrPending <= 1'b1;

      if (state == ST_IDLE) begin
        if (startRead || startWrite) begin
          state   <= ST_SYNC;
          isRead  <= startRead;
          halfCnt <= '0;
          halfIdx <= '0;
        end
      end else begin
        halfCnt <= halfDone ? '0 : halfCnt + 1'b1;
        if (halfDone) begin
          halfIdx <= halfIdx + 1'b1;
          case (state)
            ST_SYNC:  if (halfIdx == IDX_W'(1)) begin state <= ST_SHIFT; halfIdx <= '0; end
            ST_SHIFT: if (halfIdx == IDX_W'(LAST_HALF)) begin state <= ST_GAP; halfIdx <= '0; end
            ST_GAP:   if (halfIdx == IDX_W'(1)) begin state <= ST_IDLE; halfIdx <= '0; end
            default:  state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // R7: the pending flag is released only by the close of a write frame
  assert_write_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrPending) |-> ($past(state) == ST_SHIFT) && !$past(isRead));

  // R2: a read frame opens only while a ready edge is pending and the line is low
  assert_start_on_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(csN) && isRead) |-> ($past(readPend) && !$past(drdySync)));
endmodule

// File: rtl/adcrd_datapath.sv
module adcrd_datapath
  import adcrd_pkg::*;
#(
  parameter logic [CMD_W-1:0] READ_CMD = 8'h01
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                stb,
  input  logic [CMD_W-1:0]         wrCmd,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     miso,
  output logic                     sclk,
  output logic                     mosi,
  output logic signed [DATA_W-1:0] sample,
  output logic                     sampleValid
);
  logic [FRAME_W-1:0] txReg, rxReg, holdWord;

  assign mosi = txReg[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReg       <= '0;
      rxReg       <= '0;
      holdWord    <= '0;
      sclk        <= 1'b0;
      sample      <= '0;
      sampleValid <= 1'b0;
    end else begin
      if (stb.holdWrite) holdWord <= {wrCmd, wrData};

      if (stb.loadRead)       txReg <= {READ_CMD, {DATA_W{1'b0}}};
      else if (stb.loadWrite) txReg <= holdWord;
      else if (stb.fall)      txReg <= {txReg[FRAME_W-2:0], 1'b0};

      if (stb.rise) rxReg <= {rxReg[FRAME_W-2:0], miso};

      if (stb.rise)      sclk <= 1'b1;
      else if (stb.fall) sclk <= 1'b0;

      sampleValid <= stb.publish;
      if (stb.publish) sample <= rxReg[DATA_W-1:0];
    end
  end

  // R5: outgoing data holds steady through every high phase of the clock
  assert_mosi_steady_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/adc_ready_reader.sv
module adc_ready_reader
  import adcrd_pkg::*;
#(
  parameter int              SYS_CLK_HZ = 50_000_000,
  parameter int              SCLK_HZ    = 1_000_000,
  parameter logic [7:0]      READ_CMD   = 8'h01
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               drdyN,
  input  logic               miso,
  input  logic               wrReq,
  input  logic [7:0]         wrCmd,
  input  logic [23:0]        wrData,
  output logic               sclk,
  output logic               mosi,
  output logic               csN,
  output logic               fsN,
  output logic signed [23:0] sample,
  output logic               sampleValid,
  output logic               wrPending
);
  localparam int HALF    = SYS_CLK_HZ / (2 * SCLK_HZ);
  localparam int GAP_MIN = 2 * HALF;
  localparam int GAP_W   = $clog2(GAP_MIN + 1) + 1;

  dpStrobe_t stb;

  adcrd_ctrl #(.HALF(HALF)) uCtrl (
    .clk(clk), .rstN(rstN), .drdyN(drdyN), .wrReq(wrReq),
    .csN(csN), .fsN(fsN), .wrPending(wrPending), .stb(stb)
  );

  adcrd_datapath #(.READ_CMD(READ_CMD)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrCmd(wrCmd), .wrData(wrData),
    .miso(miso), .sclk(sclk), .mosi(mosi), .sample(sample),
    .sampleValid(sampleValid)
  );

  logic [GAP_W-1:0] highCnt;
  always_ff @(posedge clk) begin
    if (!rstN)    highCnt <= GAP_W'(GAP_MIN);
    else if (!csN) highCnt <= '0;
    else if (highCnt < GAP_W'(GAP_MIN)) highCnt <= highCnt + 1'b1;
  end

  // R9: chip select rests high long enough between frames
  assert_cs_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (highCnt >= GAP_W'(GAP_MIN)));

  // R9: the serial clock is idle whenever chip select is released
  assert_idle_clock_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R3: the sync pulse sits inside chip select before any clock edge
  assert_sync_lead_R3: assert property (@(posedge clk) disable iff (!rstN)
    !fsN |-> (!csN && !sclk));

  // R6: each sample strobe lasts a single cycle
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);
endmodule

// File: tb/tb_adc_ready_reader.sv
module tb_adc_ready_reader;
  localparam int CLK_PERIOD = 10;
  localparam int SYS_HZ     = 8;
  localparam int SCK_HZ     = 2;
  localparam int HALF       = SYS_HZ / (2 * SCK_HZ);
  localparam logic [7:0] RCMD = 8'h01;

  logic clk = 0, rstN = 0, drdyN = 1, wrReq = 0;
  logic [7:0] wrCmd = 0;
  logic [23:0] wrData = 0;
  logic sclk, mosi, csN, fsN, sampleValid, wrPending, miso;
  logic signed [23:0] sample;

  adc_ready_reader #(.SYS_CLK_HZ(SYS_HZ), .SCLK_HZ(SCK_HZ), .READ_CMD(RCMD)) dut (
    .clk(clk), .rstN(rstN), .drdyN(drdyN), .miso(miso), .wrReq(wrReq),
    .wrCmd(wrCmd), .wrData(wrData), .sclk(sclk), .mosi(mosi), .csN(csN),
    .fsN(fsN), .sample(sample), .sampleValid(sampleValid), .wrPending(wrPending)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vecCnt = 0, failCnt = 0;
  logic [31:0] slaveWord = 0;
  int riseCnt = 0;
  logic [31:0] mosiWord = 0;
  logic [31:0] frames [0:63];
  int frameRises [0:63];
  int frameFs [0:63];
  int frameCnt = 0;
  int validCnt = 0, fsLen = 0, gapCur = 0, minGap = 1000000, periodCnt = 0;
  int idleErr = 0, pulseErr = 0, edgeErr = 0, periodErr = 0, fsErr = 0;
  logic prevCs = 1, prevValid = 0, prevSclk = 0, prevMosi = 0;
  logic [23:0] lastSample = 0;
  bit done = 0;

  assign miso = (riseCnt < 32) ? slaveWord[31 - riseCnt] : 1'b0;

  // slave model: counts clock rises and records the outgoing word
  always @(negedge csN or posedge sclk) begin
    if (!sclk) begin
      riseCnt  = 0;
      mosiWord = 0;
    end else if (!csN) begin
      mosiWord = {mosiWord[30:0], mosi};
      riseCnt  = riseCnt + 1;
    end
  end

  always @(posedge csN) begin
    if (rstN && frameCnt < 64) begin
      frames[frameCnt]     = mosiWord;
      frameRises[frameCnt] = riseCnt;
      frameFs[frameCnt]    = fsLen;
      frameCnt = frameCnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (csN && sclk) idleErr++;
      if (prevCs && !csN) begin
        fsLen = 0;
        if (frameCnt > 0 && gapCur < minGap) minGap = gapCur;
      end
      if (csN) gapCur++; else gapCur = 0;
      if (!fsN) begin
        fsLen++;
        if (csN || riseCnt != 0) fsErr++;
      end
      if (sampleValid) begin
        validCnt++;
        lastSample = sample;
        if (prevValid) pulseErr++;
      end
      if (sclk && prevSclk && mosi != prevMosi) edgeErr++;
      if (sclk && !prevSclk) begin
        if (riseCnt > 1 && periodCnt != 2 * HALF) periodErr++;
        periodCnt = 1;
      end else periodCnt++;
      prevCs = csN; prevValid = sampleValid; prevSclk = sclk; prevMosi = mosi;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitFrames(input int n);
    for (int i = 0; i < 2000 && frameCnt < n; i++) @(negedge clk);
  endtask

  task automatic pulseWrite(input logic [7:0] c, input logic [23:0] d);
    @(negedge clk);
    wrReq = 1; wrCmd = c; wrData = d;
    @(negedge clk);
    wrReq = 0; wrCmd = 8'hEE; wrData = 24'hEEEEEE;
  endtask

  task automatic readOne(input logic [23:0] val);
    int f0, v0;
    f0 = frameCnt; v0 = validCnt;
    slaveWord = {8'h00, val};
    @(negedge clk); drdyN = 0;
    waitFrames(f0 + 1);
    repeat (3) @(negedge clk);
    // R6 R4: recovered value, wire word, one strobe
    chk(validCnt == v0 + 1, "R6 one strobe per read", validCnt, v0 + 1);
    chk(lastSample == val, "R6 sample value", {8'h0, lastSample}, {8'h0, val});
    chk(frames[f0] == {RCMD, 24'h0}, "R4 read command word", frames[f0], {RCMD, 24'h0});
    chk(frameRises[f0] == 32 && frameFs[f0] == 2 * HALF, "R3 rises and sync length",
        {frameRises[f0][15:0], frameFs[f0][15:0]}, {16'd32, 16'(2 * HALF)});
    drdyN = 1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (CLK_PERIOD * 0 + 150000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", frameCnt, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int f0, v0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(csN == 1 && fsN == 1 && sclk == 0 && sampleValid == 0 && wrPending == 0,
        "R1 reset outputs", {csN, fsN, sclk, sampleValid, wrPending}, 5'b11000);
    rstN = 1;
    repeat (4) @(negedge clk);

    // R6 R11: sweep of result patterns
    readOne(24'h000000); readOne(24'hFFFFFF); readOne(24'h7FFFFF);
    readOne(24'h800000); readOne(24'h5A5A5A); readOne(24'hA5A5A5);
    for (int b = 0; b < 24; b++) readOne(24'h1 << b);
    for (int b = 0; b < 24; b += 3) readOne(~(24'h1 << b));

    // R2: a ready line held low gives exactly one read
    f0 = frameCnt; v0 = validCnt;
    slaveWord = {8'h00, 24'h123456};
    @(negedge clk); drdyN = 0;
    repeat (600) @(negedge clk);
    chk(frameCnt == f0 + 1, "R2 single frame per edge", frameCnt, f0 + 1);
    chk(validCnt == v0 + 1 && lastSample == 24'h123456, "R2 single sample per edge",
        {8'h0, lastSample}, 32'h00123456);
    drdyN = 1;
    repeat (10) @(negedge clk);

    // R10 R4 R6: write frame while ready is high, no read and no strobe
    f0 = frameCnt; v0 = validCnt;
    pulseWrite(8'h53, 24'hC0FFEE);
    waitFrames(f0 + 1);
    repeat (300) @(negedge clk);
    chk(frameCnt == f0 + 1, "R10 only the write frame", frameCnt, f0 + 1);
    chk(frames[f0] == {8'h53, 24'hC0FFEE}, "R4 write word", frames[f0], {8'h53, 24'hC0FFEE});
    chk(validCnt == v0, "R6 no strobe on write", validCnt, v0);
    chk(wrPending == 0, "R7 pending cleared", wrPending, 0);

    // R7: request during a pending write is ignored
    f0 = frameCnt;
    pulseWrite(8'h11, 24'h222222);
    for (int i = 0; i < 100 && csN; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(wrPending == 1, "R7 pending while in flight", wrPending, 1);
    pulseWrite(8'h99, 24'h888888);
    repeat (400) @(negedge clk);
    chk(frameCnt == f0 + 1, "R7 ignored request sends nothing", frameCnt, f0 + 1);
    chk(frames[f0] == {8'h11, 24'h222222}, "R7 first request kept", frames[f0], {8'h11, 24'h222222});

    // R8: read and write both pending at idle, read goes first
    f0 = frameCnt; v0 = validCnt;
    slaveWord = {8'h00, 24'h3C3C3C};
    pulseWrite(8'h21, 24'h010203);
    for (int i = 0; i < 100 && csN; i++) @(negedge clk);
    drdyN = 0;
    for (int i = 0; i < 400 && !csN; i++) @(negedge clk);
    pulseWrite(8'h42, 24'h0A0B0C);
    waitFrames(f0 + 3);
    repeat (20) @(negedge clk);
    chk(frameCnt == f0 + 3, "R8 three frames", frameCnt, f0 + 3);
    chk(frames[f0 + 1] == {RCMD, 24'h0}, "R8 read served first", frames[f0 + 1], {RCMD, 24'h0});
    chk(frames[f0 + 2] == {8'h42, 24'h0A0B0C}, "R8 write follows", frames[f0 + 2], {8'h42, 24'h0A0B0C});
    chk(validCnt == v0 + 1 && lastSample == 24'h3C3C3C, "R8 sample from read",
        {8'h0, lastSample}, 32'h003C3C3C);
    drdyN = 1;
    repeat (10) @(negedge clk);

    // R9 R5 R11 R3: whole-run edge and spacing monitors
    chk(minGap > 2 * HALF, "R9 chip select gap", minGap, 2 * HALF + 1);
    chk(idleErr == 0, "R9 clock idle low", idleErr, 0);
    chk(edgeErr == 0, "R5 mosi steady while high", edgeErr, 0);
    chk(periodErr == 0, "R11 clock period", periodErr, 0);
    chk(pulseErr == 0, "R6 strobe width", pulseErr, 0);
    chk(fsErr == 0, "R3 sync inside select before clocks", fsErr, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end
endmodule